// File: doc/BRIEF.md
# Per-Period Step Burst Generator

This block drives the step input of one stepper-motor channel. Within each frame period it emits a programmed number of step pulses. A frame period is for example one vertical-sync interval, and each period is opened by a one-cycle period-start strobe. A control byte carries three things: a rotation-direction bit, a drive-enable bit and a 6-bit pulse-count code. The code is scaled by four, so one period holds from 0 to 252 pulses in steps of four.

The control byte is written into a pending register at any time. Its direction and enable fields reach the outputs only at the next period start, so the direction can never flip in the middle of a burst. The drive-enable output tells the downstream driver stage whether to conduct or to float its outputs.

Pulses are paced by a programmable tick divider. A pulse is high for one tick and then low for at least one tick. An inhibit input comes from the frame-integrity checker. While it is high, no new pulse starts and the remaining count is held. Each period start reloads the count and discards whatever the previous period had not yet emitted.

Top module: `step_burst_gen`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `step_out`, `dir_out` and `drive_en` are all 0.
- R2: The control byte decodes as follows: bit 7 is direction (0 forward → `dir_out`=0, 1 reverse → `dir_out`=1), bit 6 is drive enable (1 → `drive_en`=1, meaning conduct; 0 → `drive_en`=0, meaning high impedance), and bits 5..0 are the pulse-count code. The byte is captured when `ctrl_wr` is high.
- R3: A written direction or enable changes `dir_out`/`drive_en` only on the clock edge that samples `period_start` high. Before that edge the outputs keep their previous values.
- R4: After a period start, the number of rising edges on `step_out` before the next period start is exactly code×4 (0 to 252). A code of 0 gives no pulse.
- R5: With divider setting D on `div_sel`, every pulse is high for exactly D+1 clock cycles and is followed by at least D+1 low cycles. The first pulse rises D+1 cycles after the strobe edge.
- R6: A period start forces `step_out` low on that edge and reloads the count from the pending code. Pulses not yet emitted from the previous period are dropped.
- R7: While `inhibit` is high no new pulse begins. The remaining count is kept and its pulses are emitted after `inhibit` falls.
- R8: Once the count is exhausted, `step_out` stays low until the next period start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr | input | 1 | Capture `ctrl_byte` into the pending register |
| ctrl_byte | input | 8 | Direction, drive enable and pulse-count code |
| period_start | input | 1 | One-cycle strobe opening a new frame period |
| inhibit | input | 1 | Suppresses new pulses (frame checker fault) |
| div_sel | input | DIV_W | Tick divider setting D; one tick every D+1 cycles |
| step_out | output | 1 | Step pulse train |
| dir_out | output | 1 | Direction level, 1 = reverse |
| drive_en | output | 1 | 1 = driver conducts, 0 = driver high impedance |

## Verification
A table of control bytes and divider settings is applied. It covers the codes 0, 1, 5, 10, 32 and 63 and the dividers 0 to 3. The counted rising edges distinguish a correct scale-by-four from an off-by-one or unscaled count. The counted high cycles distinguish a pulse width of one tick from a width of one clock. Directed tests cover four further cases:
- a control write inside a period, showing that the direction is deferred;
- a reload in mid-burst, showing that the leftover pulses are dropped and the new count is not added to the old one;
- an inhibited period, showing that the count is held rather than lost;
- the first-pulse latency, which pins down the divider phase relative to the strobe.

// File: rtl/step_burst_pkg.sv
package step_burst_pkg;

    localparam int CODE_W   = 6;
    localparam int GRAIN_SH = 2;
    localparam int CNT_W    = CODE_W + GRAIN_SH;

    typedef struct packed {
        logic              rev;
        logic              drive;
        logic [CODE_W-1:0] code;
    } step_ctrl_t;

    typedef struct packed {
        logic rev;
        logic drive;
    } step_mode_t;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } step_phase_t;

    function automatic step_ctrl_t unpack_ctrl(input logic [7:0] b);
        step_ctrl_t c;
        c.rev   = b[7];
        c.drive = b[6];
        c.code  = b[CODE_W-1:0];
        return c;
    endfunction

    function automatic logic [CNT_W-1:0] code_to_pulses(input logic [CODE_W-1:0] c);
        return {c, {GRAIN_SH{1'b0}}};
    endfunction

endpackage

// File: rtl/ctrl_shadow.sv
module ctrl_shadow
    import step_burst_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_wr,
    input  logic [7:0]        ctrl_byte,
    input  logic              period_start,
    output logic [CODE_W-1:0] load_code,
    output logic              dir_q,
    output logic              en_q
);

    step_ctrl_t pend;
    step_mode_t act;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
        end else if (ctrl_wr) begin
            pend <= unpack_ctrl(ctrl_byte);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act <= '0;
        end else if (period_start) begin
            act.rev   <= pend.rev;
            act.drive <= pend.drive;
        end
    end

    assign load_code = pend.code;
    assign dir_q     = act.rev;
    assign en_q      = act.drive;

    // R3
    mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !period_start |=> $stable(act));

    // R3
    mode_take_chk: assert property (@(posedge clk) disable iff (rst)
        period_start |=> (act.rev == $past(pend.rev) && act.drive == $past(pend.drive)));

endmodule

// File: rtl/tick_div.sv
module tick_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic [DIV_W-1:0] div_sel,
    output logic             tick
);

    logic [DIV_W-1:0] div_cnt;

    assign tick = (div_cnt >= div_sel);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            div_cnt <= '0;
        end else if (tick) begin
            div_cnt <= '0;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

    // R5
    div_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!restart && !tick) |=> (div_cnt == $past(div_cnt) + 1'b1));

    // R5
    div_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (restart || tick) |=> (div_cnt == '0));

endmodule

// File: rtl/pulse_seq.sv
module pulse_seq
    import step_burst_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             period_start,
    input  logic [CNT_W-1:0] load_cnt,
    input  logic             tick,
    input  logic             inhibit,
    output logic             step_out
);

    logic [CNT_W-1:0] remaining;
    step_phase_t      phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            remaining <= '0;
            phase     <= PH_LOW;
        end else if (period_start) begin
            remaining <= load_cnt;
            phase     <= PH_LOW;
        end else if (tick) begin
            if (phase == PH_HIGH) begin
                phase <= PH_LOW;
            end else if (remaining != '0 && !inhibit) begin
                phase     <= PH_HIGH;
                remaining <= remaining - 1'b1;
            end
        end
    end

    assign step_out = (phase == PH_HIGH);

    // R4
    rise_needs_count_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(step_out) |-> ($past(remaining) != '0));

    // R7
    no_rise_inhibit_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(step_out) |-> !$past(inhibit));

    // R6
    reload_chk: assert property (@(posedge clk) disable iff (rst)
        period_start |=> (!step_out && remaining == $past(load_cnt)));

    // R8
    idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        (remaining == '0 && !step_out && !period_start) |=> !step_out);

endmodule

// File: rtl/step_burst_gen.sv
module step_burst_gen
    import step_burst_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctrl_wr,
    input  logic [7:0]       ctrl_byte,
    input  logic             period_start,
    input  logic             inhibit,
    input  logic [DIV_W-1:0] div_sel,
    output logic             step_out,
    output logic             dir_out,
    output logic             drive_en
);

    logic [CODE_W-1:0] load_code;
    logic              tick;

    ctrl_shadow u_shadow (
        .clk          (clk),
        .rst          (rst),
        .ctrl_wr      (ctrl_wr),
        .ctrl_byte    (ctrl_byte),
        .period_start (period_start),
        .load_code    (load_code),
        .dir_q        (dir_out),
        .en_q         (drive_en)
    );

    tick_div #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst     (rst),
        .restart (period_start),
        .div_sel (div_sel),
        .tick    (tick)
    );

    pulse_seq u_seq (
        .clk          (clk),
        .rst          (rst),
        .period_start (period_start),
        .load_cnt     (code_to_pulses(load_code)),
        .tick         (tick),
        .inhibit      (inhibit),
        .step_out     (step_out)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!step_out && !dir_out && !drive_en));

endmodule

// File: tb/sim_step_burst_gen.sv
module sim_step_burst_gen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctrl_wr = 1'b0;
    logic [7:0] ctrl_byte = '0;
    logic       period_start = 1'b0;
    logic       inhibit = 1'b0;
    logic [7:0] div_sel = '0;
    logic       step_out, dir_out, drive_en;

    int n_chk = 0;
    int n_bad = 0;
    int rises = 0;
    int highs = 0;
    int base_r = 0;
    int base_h = 0;
    logic prev = 1'b0;
    int cyc = 0;

    always #2 clk = ~clk;

    step_burst_gen #(.DIV_W(8)) u0 (
        .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .ctrl_byte(ctrl_byte),
        .period_start(period_start), .inhibit(inhibit), .div_sel(div_sel),
        .step_out(step_out), .dir_out(dir_out), .drive_en(drive_en)
    );

    // {ctrl byte, divider setting, expected pulses}
    localparam logic [23:0] VEC [6] = '{
        {8'h40, 8'd2, 8'd0},
        {8'h41, 8'd0, 8'd4},
        {8'h45, 8'd2, 8'd20},
        {8'h7F, 8'd0, 8'd252},
        {8'hCA, 8'd3, 8'd40},
        {8'h60, 8'd1, 8'd128}
    };

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst) begin
            if (step_out) highs <= highs + 1;
            if (step_out && !prev) rises <= rises + 1;
            prev <= step_out;
        end
    end

    always @(posedge clk) begin
        if (cyc > 150000) begin
            n_chk = n_chk + 1;
            n_bad = n_bad + 1;
            $display("FAIL watchdog: run hung, act=%0d exp=<150000 cycles", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk = n_chk + 1;
        if (act != exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write_ctrl(input logic [7:0] b);
        @(negedge clk);
        ctrl_wr = 1'b1;
        ctrl_byte = b;
        @(negedge clk);
        ctrl_wr = 1'b0;
    endtask

    task automatic strobe();
        @(negedge clk);
        period_start = 1'b1;
        @(negedge clk);
        period_start = 1'b0;
        base_r = rises;
        base_h = highs;
    endtask

    initial begin
        wait_cyc(3);
        // R1 reset state
        chk("R1 step_out in reset", int'(step_out), 0);
        chk("R1 dir_out in reset", int'(dir_out), 0);
        chk("R1 drive_en in reset", int'(drive_en), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 outputs after reset", int'({step_out, dir_out, drive_en}), 0);

        // vector table: R2 decode, R4 count, R5 width
        for (int v = 0; v < 6; v++) begin
            logic [7:0] b;
            int d;
            int e;
            b = VEC[v][23:16];
            d = int'(VEC[v][15:8]);
            e = int'(VEC[v][7:0]);
            div_sel = VEC[v][15:8];
            write_ctrl(b);
            strobe();
            wait_cyc((2 * e + 2) * (d + 1) + 8);
            chk($sformatf("R4 pulses vec%0d", v), rises - base_r, e);
            chk($sformatf("R5 high cycles vec%0d", v), highs - base_h, e * (d + 1));
            chk($sformatf("R2 dir vec%0d", v), int'(dir_out), int'(b[7]));
            chk($sformatf("R2 enable vec%0d", v), int'(drive_en), int'(b[6]));
        end

        // R5 first-pulse latency with D=3
        div_sel = 8'd3;
        write_ctrl(8'h41);
        strobe();
        begin
            int n;
            n = 0;
            while (!step_out && n < 50) begin
                @(negedge clk);
                n++;
            end
            chk("R5 first rise latency", n, 4);
        end
        wait_cyc(60);

        // R3 deferral: make dir=1 en=1 active, then write the opposite mid-period
        write_ctrl(8'hC1);
        strobe();
        chk("R3 applied at strobe dir", int'(dir_out), 1);
        write_ctrl(8'h05);
        wait_cyc(3);
        chk("R3 dir held before strobe", int'(dir_out), 1);
        chk("R3 enable held before strobe", int'(drive_en), 1);
        strobe();
        chk("R3 dir after strobe", int'(dir_out), 0);
        chk("R3 enable after strobe", int'(drive_en), 0);
        wait_cyc(100);

        // R6 reload drops leftover pulses
        div_sel = 8'd4;
        write_ctrl(8'hFF);
        strobe();
        wait_cyc(53);
        chk("R6 burst running before reload", int'(rises - base_r > 0), 1);
        write_ctrl(8'h41);
        strobe();
        chk("R6 step low after reload", int'(step_out), 0);
        wait_cyc(120);
        chk("R6 pulses after reload", rises - base_r, 4);

        // R7 inhibit holds count, R8 idle after exhaustion
        div_sel = 8'd1;
        write_ctrl(8'h42);
        inhibit = 1'b1;
        strobe();
        wait_cyc(40);
        chk("R7 no pulses while inhibited", rises - base_r, 0);
        inhibit = 1'b0;
        wait_cyc(40);
        chk("R7 held count emitted after release", rises - base_r, 8);
        wait_cyc(40);
        chk("R8 no extra pulses after count", rises - base_r, 8);
        chk("R8 step low when idle", int'(step_out), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule